// File: doc/BRIEF.md
# BCH Error Location Mapper

This block sits behind a BCH error locator that works on one 512-byte sector. At the start of a sector it takes the strength mode, the computed syndrome bytes and the ECC bytes read back from the spare area, together with the number of error locations the locator will return. It first decides whether there is anything to do. A sector whose syndrome is all zero is clean. A sector whose stored ECC bytes are all 0xFF is treated as an erased page. In either case the sector finishes at once as clean.

Otherwise the block takes the error bit locations one per cycle through a valid/ready handshake. For each location it issues one flip command. The command names a data byte, a byte of the stored ECC area, or marks the location as out of range. Locations count backward from the far end of the data-plus-ECC codeword. In 8-bit mode the final ECC byte is reserved and is not part of that codeword. When the last location has been mapped, the block reports how many bits it corrected and whether any location was invalid.

The block also presents the syndrome in the byte order the locator expects. This reordered syndrome is a combinational view of the syndrome input.

Top module: `bch_flip_mapper`

## Requirements
- R1: `syn_rev_o` reorders `syn_i` by byte, where byte k sits at bits [8k+7:8k].
  - 16-bit mode (`mode_i`=1): output byte k equals input byte 25-k, for all 26 bytes.
  - 8-bit mode (`mode_i`=0): output byte k equals input byte 12-k for k<13, byte 13 passes through unchanged, and bytes 14..25 are zero.
- R2: If every syndrome byte in use is zero when `start_i` is taken, the sector is skipped. The bytes in use are bytes 0..12 in 8-bit mode and bytes 0..25 in 16-bit mode. On the next cycle `done_o`=1, `skip_o`=1, `corr_cnt_o`=0 and `err_o`=0, and no location is requested. Syndrome byte 13 does not count in 8-bit mode.
- R3: If every stored ECC byte in use is 0xFF when `start_i` is taken, the sector is skipped with the same outputs as R2. The bytes in use are bytes 0..13 in 8-bit mode and bytes 0..25 in 16-bit mode.
- R4: For a location `loc`, the codeword limit L is 525 in 8-bit mode and 538 in 16-bit mode. The byte position is L-1-floor(loc/8), and `flip_bit_o` equals loc mod 8.
- R5: A byte position below 512 gives `flip_kind_o`=0 (data) and `flip_idx_o` equal to the position.
- R6: A byte position from 512 up to L-1 gives `flip_kind_o`=1 (stored ECC) and `flip_idx_o` equal to the position minus 512. This never reaches ECC byte 13 in 8-bit mode.
- R7: If floor(loc/8) is L or more, the location is invalid.
  - The flip command has `flip_kind_o`=2 and `flip_idx_o`=0.
  - `err_o` is 1 at the end of the sector.
- R8: While a sector has locations outstanding, `loc_ready_o` is 1. Each accepted location produces exactly one flip command, with `flip_valid_o` high in the cycle after acceptance.
- R9: When the last location is accepted, `done_o` is high for the following cycle together with its flip command. In that cycle `loc_ready_o` is 0, `corr_cnt_o` equals the number of data and ECC flips in the sector, and `err_o` shows whether any location was invalid. A non-skipped sector with a count of zero finishes the cycle after `start_i`.
- R10: `start_i` is ignored while a sector is in progress. Mode and count stay those of the running sector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sector; sampled only while idle |
| mode_i | input | 1 | 0 = 8-bit strength, 1 = 16-bit strength |
| syn_i | input | 208 | Computed syndrome bytes, byte k at bits [8k+7:8k] |
| ecc_i | input | 208 | Stored ECC bytes from the spare area |
| loc_cnt_i | input | 5 | Number of locations the locator will deliver |
| syn_rev_o | output | 208 | Syndrome in the order the locator expects |
| loc_valid_i | input | 1 | Location beat valid |
| loc_i | input | 13 | Error bit location |
| loc_ready_o | output | 1 | Location beat accepted when high with valid |
| flip_valid_o | output | 1 | Flip command valid |
| flip_kind_o | output | 2 | 0 data, 1 stored ECC, 2 invalid |
| flip_idx_o | output | 9 | Byte index within the target area |
| flip_bit_o | output | 3 | Bit within the byte |
| done_o | output | 1 | One-cycle sector completion pulse |
| skip_o | output | 1 | Last sector was clean or erased |
| corr_cnt_o | output | 5 | Bits corrected in the last sector |
| err_o | output | 1 | Last sector held an invalid location |

## Verification
The assertions assume the following about the inputs:
- Reset is held low from time zero.
- The locator never offers more locations than `loc_cnt_i` announced, and that count is at most 16. The corrected count relies on this to stay within range.
- `mode_i`, `syn_i` and `ecc_i` are stable during the cycle in which `start_i` is sampled.

The stimulus stays within these limits. It drives inputs only on the falling edge. It announces exactly the number of locations it then supplies, never more than 16. It raises `loc_valid_i` only after seeing `loc_ready_o` high. The one deliberate violation is a `start_i` pulse while a sector is running, which is the case R10 is meant to cover.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int unsigned DATA_BYTES = 512;
  localparam int unsigned T8_BYTES   = 14;
  localparam int unsigned T16_BYTES  = 26;
  localparam int unsigned LOC_W      = 13;
  localparam int unsigned MAX_LOCS   = 16;
  localparam int unsigned SYN_W      = T16_BYTES * 8;
  localparam int unsigned CNT_W      = $clog2(MAX_LOCS + 1);
  localparam int unsigned IDX_W      = $clog2(DATA_BYTES);

  typedef enum logic [1:0] {
    TGT_DATA = 2'd0,
    TGT_ECC  = 2'd1,
    TGT_BAD  = 2'd2
  } tgt_e;
endpackage

// File: rtl/bfm_syn_reorder.sv
module bfm_syn_reorder #(
  parameter int unsigned T8_BYTES  = bfm_pkg::T8_BYTES,
  parameter int unsigned T16_BYTES = bfm_pkg::T16_BYTES,
  localparam int unsigned SYN_W    = T16_BYTES * 8
) (
  input  logic             t16_i,
  input  logic [SYN_W-1:0] syn_i,
  output logic [SYN_W-1:0] syn_rev_o
);
  for (genvar k = 0; k < T16_BYTES; k++) begin : g_byte
    logic [7:0] b8;
    logic [7:0] b16;
    if (k < T8_BYTES - 1) begin : g_rev8
      assign b8 = syn_i[(T8_BYTES-2-k)*8 +: 8];
    end else if (k == T8_BYTES - 1) begin : g_keep8
      assign b8 = syn_i[k*8 +: 8];   // reserved byte keeps its place
    end else begin : g_zero8
      assign b8 = 8'h00;
    end
    assign b16 = syn_i[(T16_BYTES-1-k)*8 +: 8];
    assign syn_rev_o[k*8 +: 8] = t16_i ? b16 : b8;
  end
endmodule

// File: rtl/bfm_sector_screen.sv
module bfm_sector_screen #(
  parameter int unsigned T8_BYTES  = bfm_pkg::T8_BYTES,
  parameter int unsigned T16_BYTES = bfm_pkg::T16_BYTES,
  localparam int unsigned SYN_W    = T16_BYTES * 8
) (
  input  logic             t16_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic [SYN_W-1:0] ecc_i,
  output logic             clean_o,
  output logic             erased_o
);
  logic [T16_BYTES-1:0] s_ok8, s_ok16, e_ok8, e_ok16;

  for (genvar k = 0; k < T16_BYTES; k++) begin : g_byte
    logic s_zero;
    logic e_ff;
    assign s_zero    = (syn_i[k*8 +: 8] == 8'h00);
    assign e_ff      = (ecc_i[k*8 +: 8] == 8'hFF);
    assign s_ok16[k] = s_zero;
    assign e_ok16[k] = e_ff;
    // syndrome check skips the reserved byte in 8-bit mode, stored check does not
    if (k < T8_BYTES - 1) begin : g_s8
      assign s_ok8[k] = s_zero;
    end else begin : g_s8x
      assign s_ok8[k] = 1'b1;
    end
    if (k < T8_BYTES) begin : g_e8
      assign e_ok8[k] = e_ff;
    end else begin : g_e8x
      assign e_ok8[k] = 1'b1;
    end
  end

  assign clean_o  = t16_i ? &s_ok16 : &s_ok8;
  assign erased_o = t16_i ? &e_ok16 : &e_ok8;
endmodule

// File: rtl/bfm_loc_map.sv
module bfm_loc_map #(
  parameter int unsigned DATA_BYTES = bfm_pkg::DATA_BYTES,
  parameter int unsigned T8_BYTES   = bfm_pkg::T8_BYTES,
  parameter int unsigned T16_BYTES  = bfm_pkg::T16_BYTES,
  parameter int unsigned LOC_W      = bfm_pkg::LOC_W,
  localparam int unsigned IDX_W     = $clog2(DATA_BYTES)
) (
  input  logic                t16_i,
  input  logic [LOC_W-1:0]    loc_i,
  output bfm_pkg::tgt_e       kind_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [2:0]          bit_o
);
  localparam int unsigned PW    = LOC_W + 1;
  localparam int unsigned LIM8  = DATA_BYTES + T8_BYTES - 1;
  localparam int unsigned LIM16 = DATA_BYTES + T16_BYTES;

  logic [PW-1:0] lim, qx, pos;

  always_comb begin
    lim    = t16_i ? PW'(LIM16) : PW'(LIM8);
    qx     = PW'(loc_i[LOC_W-1:3]);
    pos    = lim - qx - PW'(1);
    bit_o  = loc_i[2:0];
    kind_o = bfm_pkg::TGT_BAD;
    idx_o  = '0;
    // compare before subtracting: out-of-range locations never wrap into the data
    if (qx < lim) begin
      if (pos < PW'(DATA_BYTES)) begin
        kind_o = bfm_pkg::TGT_DATA;
        idx_o  = pos[IDX_W-1:0];
      end else begin
        kind_o = bfm_pkg::TGT_ECC;
        idx_o  = pos[IDX_W-1:0] - IDX_W'(DATA_BYTES);
      end
    end
  end
endmodule

// File: rtl/bch_flip_mapper.sv
module bch_flip_mapper #(
  parameter int unsigned DATA_BYTES = bfm_pkg::DATA_BYTES,
  parameter int unsigned T8_BYTES   = bfm_pkg::T8_BYTES,
  parameter int unsigned T16_BYTES  = bfm_pkg::T16_BYTES,
  parameter int unsigned LOC_W      = bfm_pkg::LOC_W,
  parameter int unsigned MAX_LOCS   = bfm_pkg::MAX_LOCS,
  localparam int unsigned SYN_W     = T16_BYTES * 8,
  localparam int unsigned CNT_W     = $clog2(MAX_LOCS + 1),
  localparam int unsigned IDX_W     = $clog2(DATA_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic [SYN_W-1:0] ecc_i,
  input  logic [CNT_W-1:0] loc_cnt_i,
  output logic [SYN_W-1:0] syn_rev_o,
  input  logic             loc_valid_i,
  input  logic [LOC_W-1:0] loc_i,
  output logic             loc_ready_o,
  output logic             flip_valid_o,
  output logic [1:0]       flip_kind_o,
  output logic [IDX_W-1:0] flip_idx_o,
  output logic [2:0]       flip_bit_o,
  output logic             done_o,
  output logic             skip_o,
  output logic [CNT_W-1:0] corr_cnt_o,
  output logic             err_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e              state_q;
  logic             t16_q;
  logic [CNT_W-1:0] left_q, corr_q;
  logic             err_q, skip_q, done_q;
  logic             flip_v_q;
  bfm_pkg::tgt_e    flip_kind_q;
  logic [IDX_W-1:0] flip_idx_q;
  logic [2:0]       flip_bit_q;

  logic             clean, erased, accept;
  bfm_pkg::tgt_e    map_kind;
  logic [IDX_W-1:0] map_idx;
  logic [2:0]       map_bit;

  bfm_syn_reorder #(.T8_BYTES(T8_BYTES), .T16_BYTES(T16_BYTES)) u_reorder (
    .t16_i(mode_i), .syn_i(syn_i), .syn_rev_o(syn_rev_o)
  );

  bfm_sector_screen #(.T8_BYTES(T8_BYTES), .T16_BYTES(T16_BYTES)) u_screen (
    .t16_i(mode_i), .syn_i(syn_i), .ecc_i(ecc_i), .clean_o(clean), .erased_o(erased)
  );

  bfm_loc_map #(
    .DATA_BYTES(DATA_BYTES), .T8_BYTES(T8_BYTES), .T16_BYTES(T16_BYTES), .LOC_W(LOC_W)
  ) u_map (
    .t16_i(t16_q), .loc_i(loc_i), .kind_o(map_kind), .idx_o(map_idx), .bit_o(map_bit)
  );

  assign loc_ready_o = (state_q == ST_RUN);
  assign accept      = loc_valid_i && loc_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      t16_q       <= 1'b0;
      left_q      <= '0;
      corr_q      <= '0;
      err_q       <= 1'b0;
      skip_q      <= 1'b0;
      done_q      <= 1'b0;
      flip_v_q    <= 1'b0;
      flip_kind_q <= bfm_pkg::TGT_DATA;
      flip_idx_q  <= '0;
      flip_bit_q  <= '0;
    end else begin
      flip_v_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          t16_q  <= mode_i;
          corr_q <= '0;
          err_q  <= 1'b0;
          skip_q <= clean || erased;
          if (clean || erased || loc_cnt_i == '0) begin
            done_q <= 1'b1;
          end else begin
            state_q <= ST_RUN;
            left_q  <= loc_cnt_i;
          end
        end
        ST_RUN: if (accept) begin
          flip_v_q    <= 1'b1;
          flip_kind_q <= map_kind;
          flip_idx_q  <= map_idx;
          flip_bit_q  <= map_bit;
          if (map_kind == bfm_pkg::TGT_BAD) err_q <= 1'b1;
          else                              corr_q <= corr_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign flip_valid_o = flip_v_q;
  assign flip_kind_o  = flip_kind_q;
  assign flip_idx_o   = flip_idx_q;
  assign flip_bit_o   = flip_bit_q;
  assign done_o       = done_q;
  assign skip_o       = skip_q;
  assign corr_cnt_o   = corr_q;
  assign err_o        = err_q;

  AST_FLIP_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> flip_valid_o); // R8
  AST_FLIP_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flip_valid_o |-> $past(accept)); // R8
  AST_SKIP_CLEAN_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && skip_o) |-> (corr_cnt_o == '0 && !err_o)); // R2
  AST_BAD_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_valid_o && flip_kind_o == 2'd2) |-> err_o); // R7
  AST_ECC_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_valid_o && flip_kind_o == 2'd1) |->
      (flip_idx_o < (t16_q ? IDX_W'(T16_BYTES) : IDX_W'(T8_BYTES - 1)))); // R6
  AST_READY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_ready_o |-> !done_o); // R9
endmodule

// File: tb/bch_flip_mapper_tb_top.sv
module bch_flip_mapper_tb_top;
  localparam int DB  = bfm_pkg::DATA_BYTES;
  localparam int T8  = bfm_pkg::T8_BYTES;
  localparam int T16 = bfm_pkg::T16_BYTES;
  localparam int SW  = bfm_pkg::SYN_W;
  localparam int CW  = bfm_pkg::CNT_W;
  localparam int IW  = bfm_pkg::IDX_W;
  localparam int LW  = bfm_pkg::LOC_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, mode_i = 1'b0;
  logic [SW-1:0] syn_i = '0, ecc_i = '0, syn_rev_o;
  logic [CW-1:0] loc_cnt_i = '0, corr_cnt_o;
  logic          loc_valid_i = 1'b0, loc_ready_o;
  logic [LW-1:0] loc_i = '0;
  logic          flip_valid_o, done_o, skip_o, err_o;
  logic [1:0]    flip_kind_o;
  logic [IW-1:0] flip_idx_o;
  logic [2:0]    flip_bit_o;

  int n_vec = 0;
  int n_bad = 0;

  bch_flip_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .syn_i(syn_i), .ecc_i(ecc_i), .loc_cnt_i(loc_cnt_i), .syn_rev_o(syn_rev_o),
    .loc_valid_i(loc_valid_i), .loc_i(loc_i), .loc_ready_o(loc_ready_o),
    .flip_valid_o(flip_valid_o), .flip_kind_o(flip_kind_o), .flip_idx_o(flip_idx_o),
    .flip_bit_o(flip_bit_o), .done_o(done_o), .skip_o(skip_o),
    .corr_cnt_o(corr_cnt_o), .err_o(err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void exp_map(input int m, input int loc, output int k,
                                  output int idx, output int b);
    int lim, q, pos;
    lim = DB + (m != 0 ? T16 : T8 - 1);
    q   = loc / 8;
    b   = loc % 8;
    idx = 0;
    if (q >= lim) k = 2;
    else begin
      pos = lim - 1 - q;
      if (pos < DB) begin k = 0; idx = pos; end
      else begin k = 1; idx = pos - DB; end
    end
  endfunction

  task automatic start_sector(input int m, input logic [SW-1:0] s,
                              input logic [SW-1:0] e, input int cnt);
    @(negedge clk);
    mode_i = m[0]; syn_i = s; ecc_i = e; loc_cnt_i = CW'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic feed(input int m, input int loc, input int last,
                      inout int corr, inout int err);
    int ek, ei, eb;
    exp_map(m, loc, ek, ei, eb);
    chk("R8", "ready before beat", loc_ready_o, 1);
    loc_valid_i = 1'b1;
    loc_i = LW'(loc);
    @(negedge clk);
    chk("R8", "flip valid", flip_valid_o, 1);
    chk(ek == 0 ? "R5" : (ek == 1 ? "R6" : "R7"), "kind", flip_kind_o, ek);
    if (ek != 2) chk("R4", "index", flip_idx_o, ei);
    else         chk("R7", "index on invalid", flip_idx_o, 0);
    chk("R4", "bit", flip_bit_o, eb);
    if (ek == 2) err = 1; else corr++;
    if (last != 0) begin
      loc_valid_i = 1'b0;
      chk("R9", "done", done_o, 1);
      chk("R9", "corr count", corr_cnt_o, corr);
      chk("R7", "err flag", err_o, err);
      chk("R9", "ready after last", loc_ready_o, 0);
    end else begin
      chk("R9", "no early done", done_o, 0);
    end
  endtask

  task automatic chk_skip(input int exp_skip, input string req);
    chk(req, "done", done_o, 1);
    chk(req, "skip", skip_o, exp_skip);
    chk(req, "corr", corr_cnt_o, 0);
    chk(req, "err", err_o, 0);
    chk(req, "no ready", loc_ready_o, 0);
    chk(req, "no flip", flip_valid_o, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [SW-1:0] nz, s, e;
    int corr, err;
    for (int k = 0; k < T16; k++) nz[k*8 +: 8] = 8'h01;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8", "reset ready", loc_ready_o, 0);
    chk("R8", "reset flip", flip_valid_o, 0);
    chk("R9", "reset done", done_o, 0);
    chk("R9", "reset corr", corr_cnt_o, 0);
    chk("R7", "reset err", err_o, 0);

    // R1 syndrome byte order
    for (int m = 0; m < 2; m++) begin
      for (int seed = 0; seed < 4; seed++) begin
        @(negedge clk);
        mode_i = m[0];
        for (int k = 0; k < T16; k++) syn_i[k*8 +: 8] = 8'((k * 37 + seed * 11 + 1) & 255);
        #1;
        for (int k = 0; k < T16; k++) begin
          int ex;
          if (m != 0) ex = int'(syn_i[(T16-1-k)*8 +: 8]);
          else if (k < T8 - 1) ex = int'(syn_i[(T8-2-k)*8 +: 8]);
          else if (k == T8 - 1) ex = int'(syn_i[k*8 +: 8]);
          else ex = 0;
          chk("R1", "reordered byte", int'(syn_rev_o[k*8 +: 8]), ex);
        end
      end
    end

    // R2 clean screen
    s = '0; s[13*8 +: 8] = 8'hAA;
    start_sector(0, s, '0, 5);
    chk_skip(1, "R2");
    @(negedge clk);
    chk("R2", "pulse ends", done_o, 0);
    chk("R2", "stays idle", loc_ready_o, 0);
    start_sector(1, s, '0, 0);
    chk_skip(0, "R2");
    start_sector(1, '0, '0, 7);
    chk_skip(1, "R2");

    // R3 erased screen
    e = '0; for (int k = 0; k < T8; k++) e[k*8 +: 8] = 8'hFF;
    start_sector(0, nz, e, 4);
    chk_skip(1, "R3");
    e[13*8 +: 8] = 8'h00;
    start_sector(0, nz, e, 0);
    chk_skip(0, "R3");
    e = '1;
    start_sector(1, nz, e, 9);
    chk_skip(1, "R3");
    e[25*8 +: 8] = 8'hFE;
    start_sector(1, nz, e, 0);
    chk_skip(0, "R3");

    // R10 start ignored while running
    start_sector(0, nz, '0, 3);
    corr = 0; err = 0;
    start_i = 1'b1; mode_i = 1'b1; loc_cnt_i = CW'(1);
    feed(0, 0, 0, corr, err);
    start_i = 1'b0;
    chk("R10", "still running", loc_ready_o, 1);
    feed(0, 8, 0, corr, err);
    feed(0, 4096, 1, corr, err);

    // R4..R9 full location sweep, every location once per mode
    for (int m = 0; m < 2; m++) begin
      for (int sct = 0; sct < 512; sct++) begin
        start_sector(m, nz, '0, 16);
        corr = 0; err = 0;
        for (int j = 0; j < 16; j++) feed(m, j * 512 + sct, (j == 15) ? 1 : 0, corr, err);
      end
    end

    finish_run();
  end
endmodule